// File: doc/BRIEF.md
# Buffered Serial Port Bus Registers

This block is the register front end of a serial port, seen by the host as a slave on a Wishbone classic bus. Software stores outgoing bytes by writing the data register; these bytes wait in a transmit queue until the serial transmitter takes them. Bytes from the serial receiver wait in a receive queue until software reads the data register. A control register holds the receiver enable bit. Both queues have the same depth, 2^AW entries, with AW = 3 by default. Each queue drives its own empty and full status pins.

The block does no serial shifting and no baud timing. It connects to the transmitter and the receiver through byte streams that use valid/ready handshakes. On the transmit stream the block is the source. `tx_valid` is high while the transmit queue holds a byte, and `tx_byte` shows the oldest byte. That byte leaves the queue on a clock edge where `tx_valid` and `tx_ready` are both high. Until then the byte and the valid signal hold steady. On the receive stream the block is the sink. `rx_ready` is high only while the receiver is enabled and the receive queue has space. A byte enters the queue on an edge where `rx_valid` and `rx_ready` are both high. When the queue is full, the source must keep its byte until `rx_ready` returns.

The bus acknowledges an access in the same cycle as the strobe, so no wait states are inserted. If the strobe stays high, the host can write one byte on every clock. Read data comes from the queue head through combinational logic during the acknowledged cycle. The pop takes place at the closing edge of that cycle.

Top module: `sbb_top`

## Requirements
- R1: After reset both queues are empty, not full, `tx_valid` is 0, the receiver is disabled, and `rx_ready` is 0.
- R2: `bus_ack` is high in exactly those cycles where `bus_stb` and `bus_cyc` are both high, in the same cycle, whatever the address. It is never high while `bus_cyc` is low.
- R3: A write to address 0x00 appends `bus_dat_i` to the transmit queue. A strobe held for several cycles appends one byte per cycle. The bytes reach `tx_byte` in the order they were written, and a byte first shows on `tx_valid`/`tx_byte` one cycle after the edge that stored it.
- R4: After 2^AW bytes are queued without a pop, `tx_full` is 1. A further write to address 0x00 is still acknowledged, but the byte is discarded.
- R5: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle still has `tx_valid` at 1 and `tx_byte` unchanged.
- R6: A write to address 0x01 sets the receiver enable from `bus_dat_i` bit 0. A read of address 0x01 returns the enable in bit 0, with bits 7:1 at zero.
- R7: `rx_ready` is 1 exactly when the receiver is enabled and the receive queue is not full. A byte offered while the receiver is disabled is not stored.
- R8: A read of address 0x00 returns the oldest received byte during the acknowledged cycle and removes it at that cycle's edge. A read of address 0x00 with the receive queue empty returns 0x00 and leaves the queue unchanged.
- R9: After 2^AW bytes are received with no read, `rx_full` is 1 and `rx_ready` is 0. A byte offered in this state is not stored.
- R10: Either `bus_rst` or `master_rst`, held high for one clock edge, returns the block to the R1 state.
- R11: An access to any address other than 0x00 and 0x01 is acknowledged. A write there changes nothing, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| master_rst | input | 1 | Synchronous reset, active high |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| bus_adr | input | 8 | Register address |
| bus_dat_i | input | 8 | Write data |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_dat_o | output | 8 | Read data |
| bus_ack | output | 1 | Access acknowledge |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Transmitter takes `tx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Receiver offers `rx_byte` |
| rx_ready | output | 1 | Block can store a received byte |
| rx_enable | output | 1 | Receiver enable |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |

## Verification
`bus_ack`, `bus_dat_o` and `rx_ready` are combinational. The bench checks them 1 ns after the falling edge where it drove the inputs, and before the next rising edge. Queue contents, status flags, the enable bit and `tx_valid`/`tx_byte` update at the rising edge that ends the access or handshake. The bench samples these one falling edge later. While the transmit queue drains with `tx_ready` held high, each cycle's check compares `tx_byte` before the edge that pops it, so the bytes are seen in their queued order.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam logic [7:0] ADR_DATA = 8'h00;
  localparam logic [7:0] ADR_CTRL = 8'h01;

  typedef struct packed {
    logic wr_data;
    logic rd_data;
    logic wr_ctrl;
    logic rd_ctrl;
  } sbb_strobe_t;
endpackage

// File: rtl/sbb_fifo.sv
module sbb_fifo #(
  parameter int AW = 3,
  parameter int W  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  // Full and empty never coincide; a full queue with no pop stays full (R4, R9)
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  p_full_holds_r9: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> full);
  // Empty read leaves the queue empty (R8)
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    empty && !push |=> empty);
endmodule

// File: rtl/sbb_decode.sv
module sbb_decode
  import sbb_pkg::*;
(
  input  logic [7:0]  adr,
  input  logic        we,
  input  logic        stb,
  input  logic        cyc,
  output logic        ack,
  output sbb_strobe_t strb
);
  always_comb begin
    ack          = stb && cyc;
    strb.wr_data = ack &&  we && (adr == ADR_DATA);
    strb.rd_data = ack && !we && (adr == ADR_DATA);
    strb.wr_ctrl = ack &&  we && (adr == ADR_CTRL);
    strb.rd_ctrl = ack && !we && (adr == ADR_CTRL);
  end

  // At most one register access per cycle, and only inside an acknowledged cycle (R2)
  always_comb begin
    a_one_strobe_r2: assert ($onehot0(strb));
  end
endmodule

// File: rtl/sbb_top.sv
module sbb_top
  import sbb_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic       clk,
  input  logic       master_rst,
  input  logic       bus_rst,
  input  logic [7:0] bus_adr,
  input  logic [7:0] bus_dat_i,
  input  logic       bus_we,
  input  logic       bus_stb,
  input  logic       bus_cyc,
  output logic [7:0] bus_dat_o,
  output logic       bus_ack,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       rx_enable,
  output logic       rx_empty,
  output logic       rx_full,
  output logic       tx_empty,
  output logic       tx_full
);
  logic        rst;
  sbb_strobe_t strb;
  logic [7:0]  rx_head;

  assign rst = master_rst || bus_rst;

  sbb_decode u_dec (
    .adr (bus_adr),
    .we  (bus_we),
    .stb (bus_stb),
    .cyc (bus_cyc),
    .ack (bus_ack),
    .strb(strb)
  );

  sbb_fifo #(.AW(AW), .W(8)) u_txq (
    .clk  (clk),
    .rst  (rst),
    .push (strb.wr_data),
    .wdata(bus_dat_i),
    .pop  (tx_ready),
    .rdata(tx_byte),
    .empty(tx_empty),
    .full (tx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = rx_enable && !rx_full;

  sbb_fifo #(.AW(AW), .W(8)) u_rxq (
    .clk  (clk),
    .rst  (rst),
    .push (rx_valid && rx_ready),
    .wdata(rx_byte),
    .pop  (strb.rd_data),
    .rdata(rx_head),
    .empty(rx_empty),
    .full (rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst)               rx_enable <= 1'b0;
    else if (strb.wr_ctrl) rx_enable <= bus_dat_i[0];
  end

  always_comb begin
    bus_dat_o = 8'h00;
    if (strb.rd_data && !rx_empty) bus_dat_o = rx_head;
    else if (strb.rd_ctrl)         bus_dat_o = {7'b0, rx_enable};
  end

  // Held transmit byte stays put under back-pressure (R5)
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  // Enable changes only through a control write (R6)
  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_stb && bus_cyc && bus_we && bus_adr == ADR_CTRL) |=> $stable(rx_enable));
  // No ack outside a bus cycle (R2)
  p_ack_cyc_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_cyc |-> !bus_ack);
  // Receive queue fills only through the handshake (R7)
  p_rx_gate_r7: assert property (@(posedge clk) disable iff (rst)
    rx_empty && !(rx_valid && rx_enable) |=> rx_empty);
endmodule

// File: tb/tb_sbb_top.sv
module tb_sbb_top;
  logic       clk = 1'b0;
  logic       master_rst, bus_rst;
  logic [7:0] bus_adr, bus_dat_i, bus_dat_o, tx_byte, rx_byte;
  logic       bus_we, bus_stb, bus_cyc, bus_ack;
  logic       tx_valid, tx_ready, rx_valid, rx_ready, rx_enable;
  logic       rx_empty, rx_full, tx_empty, tx_full;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sbb_top #(.AW(3)) dut (
    .clk(clk), .master_rst(master_rst), .bus_rst(bus_rst),
    .bus_adr(bus_adr), .bus_dat_i(bus_dat_i), .bus_we(bus_we),
    .bus_stb(bus_stb), .bus_cyc(bus_cyc), .bus_dat_o(bus_dat_o),
    .bus_ack(bus_ack), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_enable(rx_enable), .rx_empty(rx_empty),
    .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full)
  );

  // {we, adr, wdata, expected read data}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h01, 8'h01, 8'h00},  // R6 enable
    {1'b0, 8'h01, 8'h00, 8'h01},  // R6 read back
    {1'b1, 8'h01, 8'hFE, 8'h00},  // R6 bit0 clear
    {1'b0, 8'h01, 8'h00, 8'h00},  // R6 read back
    {1'b1, 8'h07, 8'hAA, 8'h00},  // R11 write ignored
    {1'b0, 8'h07, 8'h00, 8'h00},  // R11 read zero
    {1'b0, 8'h00, 8'h00, 8'h00},  // R8 empty read
    {1'b1, 8'h01, 8'h01, 8'h00}   // R6 enable again
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_stb = 0; bus_cyc = 0; bus_we = 0; bus_adr = 0; bus_dat_i = 0;
  endtask

  // One-cycle access; read data and ack checked inside the cycle
  task automatic access(input logic we, input logic [7:0] adr, input logic [7:0] wd,
                        input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_we = we; bus_adr = adr; bus_dat_i = wd; bus_stb = 1; bus_cyc = 1;
    #1;
    chk({req, " ack"}, bus_ack, 1'b1);
    if (!we) chk({req, " rdata"}, bus_dat_o, exp);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic offer_rx(input logic [7:0] b, input logic exp_rdy, input string req);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    #1 chk({req, " rx_ready"}, rx_ready, exp_rdy);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic check_idle_state(input string req);
    #1;
    chk({req, " tx_empty"}, tx_empty, 1'b1);
    chk({req, " rx_empty"}, rx_empty, 1'b1);
    chk({req, " full flags"}, {tx_full, rx_full}, 2'b00);
    chk({req, " tx_valid/en/rdy"}, {tx_valid, rx_enable, rx_ready}, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    master_rst = 1; bus_rst = 0; tx_ready = 0; rx_valid = 0; rx_byte = 0;
    idle_bus();
    repeat (3) @(negedge clk);
    master_rst = 0;
    check_idle_state("R1");

    // Table walk
    for (int i = 0; i < NV; i++)
      access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R6/R8/R11 table");
    #1;
    chk("R11 no tx push", tx_empty, 1'b1);
    chk("R6 enable set", rx_enable, 1'b1);

    // R2: strobe without cycle
    @(negedge clk);
    bus_stb = 1; bus_we = 1; bus_adr = 8'h00; bus_dat_i = 8'h55;
    #1 chk("R2 no ack without cyc", bus_ack, 1'b0);
    @(negedge clk);
    idle_bus();
    #1 chk("R2 no push without ack", tx_empty, 1'b1);

    // R7/R8: receive and read back in order
    offer_rx(8'h3C, 1'b1, "R7");
    offer_rx(8'hC3, 1'b1, "R7");
    #1 chk("R7 stored", rx_empty, 1'b0);
    access(1'b0, 8'h00, 8'h00, 8'h3C, "R8 first");
    access(1'b0, 8'h00, 8'h00, 8'hC3, "R8 second");
    access(1'b0, 8'h00, 8'h00, 8'h00, "R8 empty");
    #1 chk("R8 empty after", rx_empty, 1'b1);

    // R7: disabled receiver drops offers
    access(1'b1, 8'h01, 8'h00, 8'h00, "R6 disable");
    offer_rx(8'h77, 1'b0, "R7 disabled");
    #1 chk("R7 not stored", rx_empty, 1'b1);
    access(1'b1, 8'h01, 8'h01, 8'h00, "R6 enable");

    // R9: fill receive queue
    for (int i = 0; i < 8; i++) offer_rx(8'h10 + 8'(i), 1'b1, "R9 fill");
    #1;
    chk("R9 rx_full", rx_full, 1'b1);
    chk("R9 rx_ready low", rx_ready, 1'b0);
    offer_rx(8'h99, 1'b0, "R9 offer when full");
    for (int i = 0; i < 8; i++) access(1'b0, 8'h00, 8'h00, 8'h10 + 8'(i), "R9 drain");
    #1 chk("R9 extra not stored", rx_empty, 1'b1);

    // R3/R4: back-to-back writes, nine into eight slots
    @(negedge clk);
    bus_we = 1; bus_adr = 8'h00; bus_stb = 1; bus_cyc = 1;
    for (int i = 0; i < 9; i++) begin
      bus_dat_i = 8'h40 + 8'(i);
      #1 chk("R2 burst ack", bus_ack, 1'b1);
      @(negedge clk);
    end
    idle_bus();
    #1;
    chk("R4 tx_full", tx_full, 1'b1);
    chk("R3 head byte", {tx_valid, tx_byte}, {1'b1, 8'h40});

    // R5: back-pressure
    repeat (3) @(negedge clk);
    #1 chk("R5 held", {tx_valid, tx_byte}, {1'b1, 8'h40});

    // R3/R4 drain in order, dropped byte absent
    @(negedge clk);
    tx_ready = 1;
    for (int i = 0; i < 8; i++) begin
      #1 chk("R3 order", {tx_valid, tx_byte}, {1'b1, 8'h40 + 8'(i)});
      @(negedge clk);
    end
    #1 chk("R4 dropped byte absent", tx_valid, 1'b0);
    tx_ready = 0;

    // R10: bus reset
    access(1'b1, 8'h00, 8'h5A, 8'h00, "R10 setup");
    offer_rx(8'hA5, 1'b1, "R10 setup");
    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
    check_idle_state("R10 bus_rst");

    // R10: master reset
    access(1'b1, 8'h01, 8'h01, 8'h00, "R10 setup");
    access(1'b1, 8'h00, 8'h5A, 8'h00, "R10 setup");
    offer_rx(8'hA5, 1'b1, "R10 setup");
    @(negedge clk); master_rst = 1;
    @(negedge clk); master_rst = 0;
    check_idle_state("R10 master_rst");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule